// File: doc/BRIEF.md
# Oversampled Serial Receiver with Spike Rejection

This block is the receive front end of an asynchronous serial port. It watches a single RX line that idles high and is paced by a sample enable that pulses sixteen times per bit period. The line first passes a two-stage synchronizer and then a spike filter. The filter only accepts a new line level after it has held for two sample pulses in a row. A falling edge on the filtered line starts a frame. The start bit is checked again half a bit later. Each data bit, least significant first, is then taken at its own midpoint, counted from that confirmed start.

Timing is rebuilt from scratch on every start bit, so a small mismatch between the sender's bit rate and the local sample rate only builds up over one word. An optional ninth data bit follows the eight data bits and is reported on its own output. After the single stop bit has been sampled, the block gives a one-cycle valid pulse together with the byte, the ninth bit and a framing-error flag. The framing-error flag is set when the stop bit reads low. Rate generation, parity, buffering and software access live elsewhere.

Top module: `uart_oversampled_rx`

## Requirements
- R1: While `rst_n` is low and right after its release, `rx_valid_o`, `rx_data_o`, `rx_bit9_o` and `rx_frame_err_o` are all zero and the receiver waits for a start bit.
- R2: Only clock cycles with `sample_en_i` high advance the filter and the frame timing. A frame driven on `rx_i` while `sample_en_i` stays low yields no `rx_valid_o`.
- R3: A low pulse on `rx_i` seen by only one sample pulse is discarded. It starts no frame, and a single-sample inversion inside a data bit leaves that bit's value unchanged.
- R4: A low level that passes the filter is checked again 8 sample pulses later. If the line reads high at that point, the receiver returns to idle and reports no frame.
- R5: With `nine_bit_i` low, each frame carries 8 data bits, least significant bit first. The byte appears on `rx_data_o` and `rx_bit9_o` is 0.
- R6: With `nine_bit_i` high when the start bit is detected, a ninth bit follows the 8 data bits and appears on `rx_bit9_o`, while the 8 data bits appear on `rx_data_o`.
- R7: `rx_frame_err_o` is 1 exactly when the stop bit sampled at its midpoint reads low, and 0 otherwise. It changes only in the cycle `rx_valid_o` is high.
- R8: Each received frame produces exactly one `rx_valid_o` pulse, one clock cycle wide. `rx_data_o` changes only with that pulse.
- R9: Sampling is re-aligned at each start bit, so back-to-back frames whose bit period is off by 3 percent in either direction are received correctly.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sample_en_i | input | 1 | Sample enable, sixteen pulses per bit period |
| rx_i | input | 1 | Asynchronous serial line, idles high |
| nine_bit_i | input | 1 | Selects a ninth data bit for frames that start while it is high |
| rx_valid_o | output | 1 | One-cycle pulse when a frame's stop bit has been sampled |
| rx_data_o | output | 8 | Received data byte |
| rx_bit9_o | output | 1 | Received ninth bit (0 in 8-bit mode) |
| rx_frame_err_o | output | 1 | Stop bit read low in the last frame |

## Verification
The hardest case to reach from the ports is a frame whose timing drifts against the local sample grid. In such a frame, the last data bit and the stop bit are sampled close to their edges. The bench gets there by defining the bit period in clock cycles instead of sample pulses and stretching or shrinking it by two cycles out of 64. It sends such frames back to back, so the next start edge lands just after the previous stop sample. Short spikes are placed at exact sample-pulse boundaries, so that one spike is seen by exactly one sample pulse and a longer one passes the filter but fails the half-bit start check.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rxs_line_cond.sv
// Synchronizer chain followed by a spike filter that only accepts a level
// held for FILT_LEN consecutive sample pulses.
module rxs_line_cond #(
  parameter int SYNC_N   = 2,
  parameter int FILT_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic rx_i,
  output logic line_o
);
  localparam int FCNT_W = $clog2(FILT_LEN + 1);

  logic [SYNC_N-1:0] sync_q, sync_d;
  logic              filt_q, filt_d;
  logic [FCNT_W-1:0] fcnt_q, fcnt_d;
  logic              synced;

  assign synced = sync_q[SYNC_N-1];

  // Synchronizer stages, one flop per stage, reset to idle-high.
  for (genvar g = 0; g < SYNC_N; g++) begin : g_sync
    if (g == 0) begin : g_first
      assign sync_d[g] = rx_i;
    end else begin : g_next
      assign sync_d[g] = sync_q[g-1];
    end
  end

  always_comb begin
    filt_d = filt_q;
    fcnt_d = fcnt_q;
    if (tick_i) begin
      if (synced == filt_q) begin
        fcnt_d = '0;
      end else if (fcnt_q == FCNT_W'(FILT_LEN - 1)) begin
        filt_d = synced;
        fcnt_d = '0;
      end else begin
        fcnt_d = fcnt_q + FCNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      filt_q <= 1'b1;
      fcnt_q <= '0;
    end else begin
      sync_q <= sync_d;
      filt_q <= filt_d;
      fcnt_q <= fcnt_d;
    end
  end

  assign line_o = filt_q;
endmodule

// File: rtl/rxs_frame_ctrl.sv
// Start confirmation, mid-bit sampling, optional ninth bit and stop check.
module rxs_frame_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              nine_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              ferr_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int MID   = OSR / 2;
  localparam int IDX_W = $clog2(DATA_W + 2);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W:0]   sh_q, sh_d;
  logic              nine_q, nine_d;
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              b9_q, b9_d;
  logic              ferr_q, ferr_d;
  logic [IDX_W-1:0]  last_idx;
  logic              bit_end;

  assign last_idx = nine_q ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
  assign bit_end  = (cnt_q == CNT_W'(OSR - 1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    nine_d  = nine_q;
    valid_d = 1'b0;
    data_d  = data_q;
    b9_d    = b9_q;
    ferr_d  = ferr_q;
    if (tick_i) begin
      case (state_q)
        ST_IDLE: begin
          if (!line_i) begin
            state_d = ST_START;
            cnt_d   = '0;
            nine_d  = nine_i;
          end
        end
        ST_START: begin
          if (cnt_q == CNT_W'(MID - 1)) begin
            cnt_d   = '0;
            idx_d   = '0;
            state_d = line_i ? ST_IDLE : ST_DATA;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            cnt_d = '0;
            sh_d  = {line_i, sh_q[DATA_W:1]};
            idx_d = idx_q + IDX_W'(1);
            if (idx_q == last_idx) state_d = ST_STOP;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_STOP: begin
          if (bit_end) begin
            cnt_d   = '0;
            state_d = ST_IDLE;
            valid_d = 1'b1;
            ferr_d  = !line_i;
            if (nine_q) begin
              data_d = sh_q[DATA_W-1:0];
              b9_d   = sh_q[DATA_W];
            end else begin
              data_d = sh_q[DATA_W:1];
              b9_d   = 1'b0;
            end
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      nine_q  <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
      b9_q    <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      nine_q  <= nine_d;
      valid_q <= valid_d;
      data_q  <= data_d;
      b9_q    <= b9_d;
      ferr_q  <= ferr_d;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign bit9_o  = b9_q;
  assign ferr_o  = ferr_q;
endmodule

// File: rtl/uart_oversampled_rx.sv
module uart_oversampled_rx #(
  parameter int OSR      = 16,
  parameter int FILT_LEN = 2,
  parameter int SYNC_N   = 2,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en_i,
  input  logic              rx_i,
  input  logic              nine_bit_i,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_bit9_o,
  output logic              rx_frame_err_o
);
  logic line_filt;

  rxs_line_cond #(
    .SYNC_N  (SYNC_N),
    .FILT_LEN(FILT_LEN)
  ) i_line_cond (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_i(sample_en_i),
    .rx_i  (rx_i),
    .line_o(line_filt)
  );

  rxs_frame_ctrl #(
    .OSR   (OSR),
    .DATA_W(DATA_W)
  ) i_frame_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (sample_en_i),
    .line_i (line_filt),
    .nine_i (nine_bit_i),
    .valid_o(rx_valid_o),
    .data_o (rx_data_o),
    .bit9_o (rx_bit9_o),
    .ferr_o (rx_frame_err_o)
  );
endmodule

// File: rtl/uart_oversampled_rx_chk.sv
module uart_oversampled_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_en_i,
  input logic              line_filt,
  input logic              rx_valid_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_bit9_o,
  input logic              rx_frame_err_o
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rx_valid_o && rx_data_o == '0 && !rx_bit9_o && !rx_frame_err_o));

  p_filter_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_filt) |-> $past(sample_en_i));

  p_valid_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> $past(sample_en_i));

  p_ferr_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_frame_err_o) |-> rx_valid_o);

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  p_data_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data_o) |-> rx_valid_o);
endmodule

bind uart_oversampled_rx uart_oversampled_rx_chk #(.DATA_W(DATA_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sample_en_i   (sample_en_i),
  .line_filt     (line_filt),
  .rx_valid_o    (rx_valid_o),
  .rx_data_o     (rx_data_o),
  .rx_bit9_o     (rx_bit9_o),
  .rx_frame_err_o(rx_frame_err_o)
);

// File: tb/test_uart_oversampled_rx.sv
module test_uart_oversampled_rx;
  localparam int TDIV  = 4;          // clocks per sample pulse
  localparam int NBIT  = 16 * TDIV;  // nominal bit period in clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_en = 1'b0;
  logic       rx = 1'b1;
  logic       nine = 1'b0;
  logic       valid;
  logic [7:0] data;
  logic       bit9;
  logic       ferr;

  int  errors = 0;
  int  checks = 0;
  bit  tick_on = 1'b1;
  bit  done = 1'b0;
  int  cap_n = 0;
  int  wide_n = 0;
  logic [7:0] cap_data [8];
  logic       cap_b9 [8];
  logic       cap_fe [8];
  logic       prev_valid = 1'b0;

  uart_oversampled_rx i_uart_oversampled_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .sample_en_i   (sample_en),
    .rx_i          (rx),
    .nine_bit_i    (nine),
    .rx_valid_o    (valid),
    .rx_data_o     (data),
    .rx_bit9_o     (bit9),
    .rx_frame_err_o(ferr)
  );

  always #2 clk = ~clk;

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      sample_en = tick_on && (div == 0);
      div = (div == TDIV - 1) ? 0 : div + 1;
    end
  end

  always @(negedge clk) begin
    if (valid) begin
      if (cap_n < 8) begin
        cap_data[cap_n] = data;
        cap_b9[cap_n]   = bit9;
        cap_fe[cap_n]   = ferr;
      end
      cap_n = cap_n + 1;
      if (prev_valid) wide_n = wide_n + 1;
    end
    prev_valid = valid;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] v, input bit nine_m, input bit stop_v,
                            input int bit_clk, input int glitch_bit);
    int nbits;
    nbits = nine_m ? 9 : 8;
    rx = 1'b0;
    clocks(bit_clk);
    for (int i = 0; i < nbits; i++) begin
      rx = v[i];
      if (i == glitch_bit) begin
        clocks(bit_clk / 2);
        rx = ~v[i];
        clocks(TDIV);
        rx = v[i];
        clocks(bit_clk - bit_clk / 2 - TDIV);
      end else begin
        clocks(bit_clk);
      end
    end
    rx = stop_v;
    clocks(bit_clk);
    rx = 1'b1;
  endtask

  task automatic expect_frame(input string tag, input int idx, input logic [7:0] d,
                              input logic b9, input logic fe);
    check(cap_data[idx] == d, {tag, " data"}, cap_data[idx], d);
    check(cap_b9[idx] == b9, {tag, " bit9"}, cap_b9[idx], b9);
    check(cap_fe[idx] == fe, {tag, " ferr"}, cap_fe[idx], fe);
  endtask

  task automatic t_reset();
    check(valid == 1'b0 && data == 8'h00 && bit9 == 1'b0 && ferr == 1'b0,
          "R1 outputs in reset", {valid, bit9, ferr, data}, 0);
    clocks(3);
    rst_n = 1'b1;
    clocks(2 * NBIT);
    check(valid == 1'b0 && data == 8'h00 && bit9 == 1'b0 && ferr == 1'b0,
          "R1 outputs after release", {valid, bit9, ferr, data}, 0);
    check(cap_n == 0, "R1 no frame after release", cap_n, 0);
  endtask

  task automatic t_eight_bit();
    logic [7:0] pats [4];
    pats = '{8'hA5, 8'h3C, 8'h00, 8'hFF};
    nine = 1'b0;
    for (int k = 0; k < 4; k++) begin
      cap_n = 0;
      send_frame({1'b0, pats[k]}, 1'b0, 1'b1, NBIT, -1);
      clocks(NBIT);
      check(cap_n == 1, "R8 one pulse per frame", cap_n, 1);
      expect_frame("R5 8-bit LSB first", 0, pats[k], 1'b0, 1'b0);
    end
  endtask

  task automatic t_nine_bit();
    logic [8:0] pats [3];
    pats = '{9'h15A, 9'h0C3, 9'h1FF};
    nine = 1'b1;
    for (int k = 0; k < 3; k++) begin
      cap_n = 0;
      send_frame(pats[k], 1'b1, 1'b1, NBIT, -1);
      clocks(NBIT);
      check(cap_n == 1, "R6 one frame", cap_n, 1);
      expect_frame("R6 9-bit", 0, pats[k][7:0], pats[k][8], 1'b0);
    end
    nine = 1'b0;
  endtask

  task automatic t_frame_err();
    cap_n = 0;
    send_frame(9'h096, 1'b0, 1'b0, NBIT, -1);
    clocks(2 * NBIT);
    check(cap_n == 1, "R7 frame with bad stop", cap_n, 1);
    expect_frame("R7 stop low", 0, 8'h96, 1'b0, 1'b1);
    check(ferr == 1'b1, "R7 flag holds", ferr, 1);
    cap_n = 0;
    send_frame(9'h069, 1'b0, 1'b1, NBIT, -1);
    clocks(NBIT);
    expect_frame("R7 stop high clears", 0, 8'h69, 1'b0, 1'b0);
  endtask

  task automatic t_spike();
    cap_n = 0;
    rx = 1'b0;
    clocks(TDIV);
    rx = 1'b1;
    clocks(3 * NBIT);
    check(cap_n == 0, "R3 one-sample spike ignored", cap_n, 0);
    send_frame(9'h0F0, 1'b0, 1'b1, NBIT, 3);
    clocks(NBIT);
    check(cap_n == 1, "R3 frame after spike", cap_n, 1);
    expect_frame("R3 glitch inside data bit", 0, 8'hF0, 1'b0, 1'b0);
  endtask

  task automatic t_false_start();
    cap_n = 0;
    rx = 1'b0;
    clocks(5 * TDIV);
    rx = 1'b1;
    clocks(3 * NBIT);
    check(cap_n == 0, "R4 false start rejected", cap_n, 0);
    send_frame(9'h0E1, 1'b0, 1'b1, NBIT, -1);
    clocks(NBIT);
    expect_frame("R4 idle after false start", 0, 8'hE1, 1'b0, 1'b0);
  endtask

  task automatic t_no_tick();
    cap_n = 0;
    tick_on = 1'b0;
    clocks(TDIV);
    send_frame(9'h055, 1'b0, 1'b1, NBIT, -1);
    clocks(NBIT);
    check(cap_n == 0, "R2 no frame without sample enable", cap_n, 0);
    tick_on = 1'b1;
    clocks(2 * NBIT);
    check(cap_n == 0, "R2 nothing pending after enable returns", cap_n, 0);
    send_frame(9'h0AA, 1'b0, 1'b1, NBIT, -1);
    clocks(NBIT);
    expect_frame("R2 normal frame afterwards", 0, 8'hAA, 1'b0, 1'b0);
  endtask

  task automatic t_drift();
    cap_n = 0;
    send_frame(9'h081, 1'b0, 1'b1, NBIT + 2, -1);
    send_frame(9'h07E, 1'b0, 1'b1, NBIT + 2, -1);
    send_frame(9'h0C5, 1'b0, 1'b1, NBIT - 2, -1);
    send_frame(9'h03A, 1'b0, 1'b1, NBIT - 2, -1);
    clocks(NBIT);
    check(cap_n == 4, "R9 four back-to-back frames", cap_n, 4);
    expect_frame("R9 slow 1", 0, 8'h81, 1'b0, 1'b0);
    expect_frame("R9 slow 2", 1, 8'h7E, 1'b0, 1'b0);
    expect_frame("R9 fast 1", 2, 8'hC5, 1'b0, 1'b0);
    expect_frame("R9 fast 2", 3, 8'h3A, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    t_reset();
    t_eight_bit();
    t_nine_bit();
    t_frame_err();
    t_spike();
    t_false_start();
    t_no_tick();
    t_drift();
    check(wide_n == 0, "R8 valid never wider than one cycle", wide_n, 0);
    done = 1'b1;
    finish_run();
  end

  initial begin
    clocks(200000 - 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end
endmodule